// File: doc/BRIEF.md
# Descriptor-Ring Playback DMA Channel

This block is a single playback channel that masters memory reads. It walks a circular list of 32 buffer descriptors in memory and moves 16-bit samples into a small local FIFO. A codec-side consumer pulls samples from the FIFO one at a time. Software programs the channel through a byte-wide register window. It sets where the descriptor list lives, how far the channel may go (the last valid index), which events raise the interrupt, and whether the channel runs, pauses or resets.

Each descriptor is two 32-bit words. The first word is the buffer start address. The second word gives the buffer length in samples, a request for an interrupt when the buffer completes, and a choice of what to play if data runs dry. The channel moves on descriptor by descriptor. It stops after the descriptor whose index equals the last valid index, and starts again as soon as software moves that index forward. When the consumer asks for a sample and the FIFO is empty, the channel flags a FIFO error and supplies a filler sample. The filler is either the last sample again or zero, as the current descriptor selects.

Register window (byte offsets, 4-bit address):

| Offset | Access | Content |
|--------|--------|---------|
| 0x0-0x3 | R/W | descriptor list start, little-endian bytes, bits 2:0 forced to 0 |
| 0x4 | R | current index |
| 0x5 | R/W | last valid index |
| 0x6 | R/W1C | status |
| 0x8-0x9 | R | samples left in the current buffer |
| 0xA | R | prefetched (next) index |
| 0xB | R/W | control |

Top module: `audio_ring_dma`

## Requirements
- R1: After reset the status byte (0x6) reads 0x01, the current index, the last valid index, the control byte and the sample count read 0, and irq is low.
- R2: Descriptor n is read as two words, at list start + 8*n and then at list start + 8*n + 4. Word 0 is the buffer address. In word 1, bits 15:0 give the length in samples, bit 31 requests a completion interrupt and bit 30 selects zero fill (1) or repeat-last fill (0).
- R3: Samples reach the consumer in ascending address order, taken from bits 15:0 of the fetched word when address bit 1 is 0 and from bits 31:16 otherwise. At most one memory read is outstanding, and mem_req with mem_addr stays stable until mem_rvalid.
- R4: Each finished descriptor (not the last valid one) advances the current index by one. Each loaded descriptor sets the prefetched index to its own index plus one and loads the sample count from its length.
- R5: After finishing the descriptor at the last valid index the channel stops reading and sets status bits 2 and 0. A later write of a different last valid index restarts it at the current index plus one and clears bit 0.
- R6: Status bit 3 is set when a descriptor with bit 31 set completes, and only then.
- R7: Status bit 1 is set when a descriptor is loaded whose index equals the last valid index.
- R8: Writing 1 to status bits 4..1 clears them. Writing bit 0 has no effect. A set event in the same cycle as a clear wins.
- R9: irq is high exactly when (status bit 3 and control bit 4) or (status bit 4 and control bit 3) or (status bit 2 and control bit 2).
- R10: A sample request while the FIFO is empty sets status bit 4. smp_out then repeats its last value when the current descriptor's bit 30 is 0, and becomes 0 when it is 1.
- R11: Control bit 0 at 0 pauses the channel, which issues no new reads. Control bit 0 reads back 1 while a read is still outstanding. Status bit 0 is set once the paused channel is idle, and setting control bit 0 again resumes where the channel stopped.
- R12: Writing control bit 1 resets the channel once no read is outstanding. The indices, the sample count and the control byte become 0, status becomes 0x01, the FIFO empties and the bit clears itself.
- R13: The current index wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_wr | input | 1 | register byte write strobe |
| reg_addr | input | 4 | register byte offset |
| reg_wdata | input | 8 | register write byte |
| reg_rdata | output | 8 | register read byte (combinational) |
| mem_req | output | 1 | memory read request, held until response |
| mem_addr | output | 32 | word-aligned read address |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | 32 | read data |
| smp_take | input | 1 | consumer takes one sample |
| smp_out | output | 16 | sample delivered on the cycle after smp_take |
| irq | output | 1 | interrupt request |

## Verification
The status byte has two writers that can act in the same clock: an underrun raised by the consumer, and a software write-1-to-clear. The bench stops the ring with the FIFO drained. It then asserts smp_take and a status write of 0x1E in the same cycle. It expects bit 4 to survive while bits 2 and 1 clear, so the byte reads 0x11. A later plain clear of bit 4 must bring the byte back to 0x01 and drop irq.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int FIFO_DEPTH = 8,
  parameter int IDX_W      = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        smp_take,
  output logic [15:0] smp_out,
  output logic        irq
);

  localparam int PW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNTW = PW + 1;
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(FIFO_DEPTH);

  typedef enum logic [2:0] {ST_IDLE, ST_DESC0, ST_DESC1, ST_DATA, ST_END} st_t;

  st_t              st;
  logic [31:0]      list_base;
  logic [IDX_W-1:0] civ, lvi, piv;
  logic [4:0]       sr;
  logic [15:0]      left;
  logic [2:0]       ie;
  logic             run, rst_pend;
  logic [31:0]      cur_addr;
  logic             d_ioc, d_zero;

  logic [15:0]      fifo [FIFO_DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CNTW-1:0]  cnt;

  wire wr_sr = reg_wr && reg_addr == 4'h6;
  wire wr_cr = reg_wr && reg_addr == 4'hB;
  wire can_go = run && !rst_pend && !mem_req;
  wire got = mem_req && mem_rvalid;
  wire push = got && st == ST_DATA;
  wire pop = smp_take && cnt != '0;
  wire [15:0] in_smp = cur_addr[1] ? mem_rdata[31:16] : mem_rdata[15:0];
  wire [31:0] desc_addr = list_base + 32'({civ, 3'b000});

  logic        issue;
  logic [31:0] issue_addr;

  always_comb begin
    issue = 1'b0;
    issue_addr = desc_addr;
    case (st)
      ST_DESC0: issue = can_go;
      ST_DESC1: begin issue = can_go; issue_addr = desc_addr + 32'd4; end
      ST_DATA: begin
        issue = can_go && left != '0 && cnt < FULL_CNT;
        issue_addr = {cur_addr[31:2], 2'b00};
      end
      default: issue = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      4'h0: reg_rdata = list_base[7:0];
      4'h1: reg_rdata = list_base[15:8];
      4'h2: reg_rdata = list_base[23:16];
      4'h3: reg_rdata = list_base[31:24];
      4'h4: reg_rdata = 8'(civ);
      4'h5: reg_rdata = 8'(lvi);
      4'h6: reg_rdata = {3'b000, sr};
      4'h8: reg_rdata = left[7:0];
      4'h9: reg_rdata = left[15:8];
      4'hA: reg_rdata = 8'(piv);
      4'hB: reg_rdata = {3'b000, ie, rst_pend, run | mem_req};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = (sr[3] & ie[2]) | (sr[4] & ie[1]) | (sr[2] & ie[0]);

  always_ff @(posedge clk) if (push) fifo[wp] <= in_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; list_base <= '0; civ <= '0; lvi <= '0; piv <= '0;
      sr <= 5'h01; left <= '0; ie <= '0; run <= 1'b0; rst_pend <= 1'b0;
      cur_addr <= '0; d_ioc <= 1'b0; d_zero <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0; smp_out <= '0;
      mem_req <= 1'b0; mem_addr <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          4'h0: list_base[7:0]   <= {reg_wdata[7:3], 3'b000};
          4'h1: list_base[15:8]  <= reg_wdata;
          4'h2: list_base[23:16] <= reg_wdata;
          4'h3: list_base[31:24] <= reg_wdata;
          4'h5: lvi <= reg_wdata[IDX_W-1:0];
          default: ;
        endcase
      end
      if (wr_sr) sr[4:1] <= sr[4:1] & ~reg_wdata[4:1];
      if (wr_cr) begin
        run <= reg_wdata[0];
        ie <= reg_wdata[4:2];
        if (reg_wdata[1]) rst_pend <= 1'b1;
      end

      if (push) wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) begin
        rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
        smp_out <= fifo[rp];
      end else if (smp_take) begin
        if (d_zero) smp_out <= '0;
        sr[4] <= 1'b1;
      end
      cnt <= cnt + CNTW'(push) - CNTW'(pop);

      if (st != ST_END) sr[0] <= !run && !mem_req;

      if (got) begin
        mem_req <= 1'b0;
        case (st)
          ST_DESC0: begin
            cur_addr <= {mem_rdata[31:1], 1'b0};
            st <= ST_DESC1;
          end
          ST_DESC1: begin
            left <= mem_rdata[15:0];
            d_ioc <= mem_rdata[31];
            d_zero <= mem_rdata[30];
            piv <= civ + 1'b1;
            if (civ == lvi) sr[1] <= 1'b1;
            st <= ST_DATA;
          end
          ST_DATA: begin
            cur_addr <= cur_addr + 32'd2;
            left <= left - 16'd1;
          end
          default: ;
        endcase
      end else if (issue) begin
        mem_req <= 1'b1;
        mem_addr <= issue_addr;
      end

      case (st)
        ST_IDLE: if (run && !rst_pend) st <= ST_DESC0;
        ST_DATA: if (!mem_req && left == '0) begin
          if (d_ioc) sr[3] <= 1'b1;
          if (civ == lvi) begin
            sr[2] <= 1'b1;
            sr[0] <= 1'b1;
            st <= ST_END;
          end else begin
            civ <= civ + 1'b1;
            st <= ST_DESC0;
          end
        end
        ST_END: if (run && !rst_pend && lvi != civ) begin
          civ <= civ + 1'b1;
          sr[0] <= 1'b0;
          st <= ST_DESC0;
        end
        default: ;
      endcase

      if (rst_pend && !mem_req) begin
        st <= ST_IDLE; civ <= '0; lvi <= '0; piv <= '0; left <= '0;
        sr <= 5'h01; ie <= '0; run <= 1'b0; rst_pend <= 1'b0;
        wp <= '0; rp <= '0; cnt <= '0;
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_req) |-> $past(mem_rvalid));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    civ != $past(civ) |-> (civ == $past(civ) + 1'b1) || (civ == '0));

  assert_end_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_END |-> sr[0]);

  assert_paused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !mem_req |=> !mem_req);

  always_ff @(posedge clk)
    if (rst_n) assert_fifo_bound_R3: assert (cnt <= FULL_CNT);

endmodule

// File: tb/sim_audio_ring_dma.sv
`timescale 1ns/1ps
module sim_audio_ring_dma;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        smp_take = 1'b0;
  logic [15:0] smp_out;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [1024];
  logic [1:0]  lat = '0;

  audio_ring_dma u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .smp_take(smp_take), .smp_out(smp_out),
    .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (mem_req) begin
      if (lat == 2'd1) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        lat <= '0;
      end else lat <= lat + 1'b1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic take(output logic [15:0] v);
    @(negedge clk); smp_take = 1'b1;
    @(negedge clk); smp_take = 1'b0; #1 v = smp_out;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] base, input logic [15:0] len,
                          input logic ioc, input logic zero);
    mem[64 + 2*idx] = base;
    mem[65 + 2*idx] = {ioc, zero, 14'd0, len};
  endtask

  task automatic put_samples(input logic [31:0] base, input logic [15:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      a = base + 32'(2*i);
      if (a[1]) mem[a[11:2]][31:16] = first + 16'(i);
      else      mem[a[11:2]][15:0]  = first + 16'(i);
    end
  endtask

  task automatic wait_halt(input string req);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(4'h6, s);
      if (s[2]) break;
    end
    chk(req, int'(s[2]), 1);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'h6, v); chk("R1 status", v, 8'h01);
    rd(4'h4, v); chk("R1 cur index", v, 0);
    rd(4'h5, v); chk("R1 last valid", v, 0);
    rd(4'hB, v); chk("R1 control", v, 0);
    rd(4'h8, v); chk("R1 count", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    logic [15:0] s;
    put_desc(0, 32'h400, 16'd4, 1'b1, 1'b0);
    put_desc(1, 32'h502, 16'd3, 1'b0, 1'b0);
    put_samples(32'h400, 16'hA000, 4);
    put_samples(32'h502, 16'hB000, 3);
    wr(4'h1, 8'h01);
    wr(4'h5, 8'h01);
    wr(4'hB, 8'h11);
    for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
    chk("R2 first descriptor address", mem_addr, 32'h100);
    wait_halt("R5 halt after last valid");
    rd(4'h6, v);
    chk("R5 status halted+done", v & 8'h05, 8'h05);
    chk("R6 completion flag", v & 8'h08, 8'h08);
    chk("R7 index-equals-last flag", v & 8'h02, 8'h02);
    rd(4'h4, v); chk("R4 current index", v, 1);
    rd(4'hA, v); chk("R4 prefetched index", v, 2);
    rd(4'h8, v); chk("R4 count empty", v, 0);
    chk("R9 irq on completion", irq, 1);
    for (int i = 0; i < 4; i++) begin take(s); chk("R3 sample A", s, 16'hA000 + 16'(i)); end
    for (int i = 0; i < 3; i++) begin take(s); chk("R3 sample B", s, 16'hB000 + 16'(i)); end
    take(s); chk("R10 repeat fill", s, 16'hB002);
    rd(4'h6, v); chk("R10 fifo error", v, 8'h1F);
    wr(4'h6, 8'h1F);
    rd(4'h6, v); chk("R8 clear keeps bit0", v, 8'h01);
    chk("R9 irq cleared", irq, 0);
  endtask

  task automatic t_resume;
    logic [7:0] v;
    logic [15:0] s;
    put_desc(2, 32'h600, 16'd2, 1'b0, 1'b1);
    put_samples(32'h600, 16'hC000, 2);
    wr(4'h5, 8'h02);
    wait_halt("R5 resume then halt");
    rd(4'h6, v); chk("R5 status after resume", v, 8'h07);
    rd(4'h4, v); chk("R5 index advanced", v, 2);
    chk("R9 no irq without enabled cause", irq, 0);
    take(s); chk("R3 sample C0", s, 16'hC000);
    take(s); chk("R3 sample C1", s, 16'hC001);
    take(s); chk("R10 zero fill", s, 16'h0000);
    rd(4'h6, v); chk("R10 fifo error set", v, 8'h17);
    wr(4'hB, 8'h19);
    chk("R9 irq on fifo error", irq, 1);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    @(negedge clk); smp_take = 1'b1; reg_wr = 1'b1; reg_addr = 4'h6; reg_wdata = 8'h1E;
    @(negedge clk); smp_take = 1'b0; reg_wr = 1'b0;
    rd(4'h6, v); chk("R8 set wins over clear", v, 8'h11);
    chk("R10 zero fill again", smp_out, 0);
    wr(4'h6, 8'h10);
    rd(4'h6, v); chk("R8 plain clear", v, 8'h01);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_pause;
    logic [7:0] v;
    logic [15:0] s;
    int seen;
    put_desc(3, 32'h700, 16'd8, 1'b0, 1'b0);
    put_samples(32'h700, 16'hD000, 8);
    wr(4'h5, 8'h03);
    for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
    wr(4'hB, 8'h00);
    rd(4'hB, v); chk("R11 control busy readback", v, 8'h01);
    repeat (6) @(negedge clk);
    rd(4'hB, v); chk("R11 control idle readback", v, 8'h00);
    rd(4'h6, v); chk("R11 halted while paused", v, 8'h01);
    seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (mem_req) seen++; end
    chk("R11 no reads while paused", seen, 0);
    wr(4'hB, 8'h01);
    wait_halt("R11 resume completes");
    rd(4'h6, v); chk("R5 status after drain", v, 8'h07);
    for (int i = 0; i < 8; i++) begin take(s); chk("R3 sample D", s, 16'hD000 + 16'(i)); end
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    put_desc(0, 32'h0, 16'd0, 1'b0, 1'b0);
    put_desc(1, 32'h0, 16'd0, 1'b0, 1'b0);
    wr(4'h6, 8'h1E);
    wr(4'h5, 8'h01);
    wait_halt("R13 wrap halt");
    rd(4'h4, v); chk("R13 index wrapped", v, 1);
    rd(4'hA, v); chk("R13 prefetched after wrap", v, 2);
  endtask

  task automatic t_chan_reset;
    logic [7:0] v;
    wr(4'hB, 8'h02);
    @(negedge clk);
    rd(4'h4, v); chk("R12 index cleared", v, 0);
    rd(4'h5, v); chk("R12 last valid cleared", v, 0);
    rd(4'h6, v); chk("R12 status", v, 8'h01);
    rd(4'hB, v); chk("R12 control self-clears", v, 0);
    rd(4'hA, v); chk("R12 prefetched cleared", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_resume();
    t_same_cycle();
    t_pause();
    t_wrap();
    t_chan_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule